// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block gathers a parameterized number of interrupt lines (a multiple of 32, at most 1024) and presents them to a single processor as one request output. Software configures it through a 32-bit register bus: a distribution section (`bus_addr[12]` = 0) holds the global forward enable and the per-line enable, priority, target and trigger settings, and a processor section (`bus_addr[12]` = 1) holds the signalling enable, the priority mask, the preemption setting and the acknowledge and retire registers.

Of all enabled, pending lines that are not in service, the controller picks the one with the numerically lowest priority; equal priorities go to the lowest ID. That line is signalled only if both enables are set, its priority is below the mask and no line is already in service. A read of the acknowledge register claims the line and returns its ID. A write of that ID to the retire register ends service. Read data appears on `bus_rdata` the cycle after `bus_re`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The type register (distribution offset 0x004) reads `NUM_IRQ/32 - 1` in bits [4:0] and zero in bits [7:5] and above.
- R2: Writing a 1 to a bit of an enable-set word (0x100 + 4*w) enables line 32*w+bit, and writing a 1 to the same bit of an enable-clear word (0x180 + 4*w) disables it. Zero bits leave the line unchanged. Both words read back the current enables.
- R3: Priority words (0x400 + 4*w) hold one byte per line (line 4*w+k in bits [8k+7:8k]). Only the top `PRIO_BITS` bits of each byte are kept and the lower bits read as zero, so with `PRIO_BITS` = 5 a write of 0xFF reads back as 0xF8.
- R4: Target words (0x800 + 4*w, one byte per line) and trigger words (0xC00 + 4*w, two bits per line) read back what was written. In a trigger field, bit 1 = 1 selects edge and 0 selects level.
- R5: `irq_req` is high only while distribution control bit 0 and processor control bit 0 (processor offset 0x00) are both 1, and an enabled pending line that is not in service has a priority value strictly below the mask (processor offset 0x04, 8 bits).
- R6: A read of the acknowledge register (processor offset 0x0C) while `irq_req` is high returns the winner's ID in bits [9:0] and zero above. The winner is the lowest priority value, and on a tie the lowest ID. That line enters service.
- R7: An acknowledge read while `irq_req` is low returns 1023 and changes no state.
- R8: A level line is pending exactly while its input is high. An edge line latches pending on a rising input, even while disabled, and the acknowledge of that line clears the latch.
- R9: While any line is in service, `irq_req` stays low and acknowledge reads return 1023. A write to the retire register (processor offset 0x10, ID in bits [9:0]) ends service of the matching line. A retire write naming a line not in service is ignored.
- R10: The mask register stores 8 bits and the preemption register (processor offset 0x08) stores 3 bits, and both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 13 | Byte address; bit 12 selects the processor section |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; acknowledge reads have side effects |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_re` |
| irq_lines | input | NUM_IRQ | Interrupt inputs |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a level line in service whose input is still high. In that state the line is pending and claimed at once, and the retire must hand it straight back to the request output. The stimulus holds the input high across acknowledge and retire, tries a retire with a wrong ID first, and then drops the line to show that pending follows the input. Tie-breaking is reached by raising three shared lines together, two with equal priority, and retiring them one by one. An edge latch is reached by pulsing a disabled line and enabling it afterwards.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // distribution section offsets
  localparam logic [11:0] D_CTRL   = 12'h000;
  localparam logic [11:0] D_TYPE   = 12'h004;
  localparam logic [11:0] D_SETEN  = 12'h100;
  localparam logic [11:0] D_CLREN  = 12'h180;
  localparam logic [11:0] D_PRIO   = 12'h400;
  localparam logic [11:0] D_TARGET = 12'h800;
  localparam logic [11:0] D_CFG    = 12'hC00;

  // processor section offsets
  localparam logic [4:0] C_CTRL = 5'h00;
  localparam logic [4:0] C_PMR  = 5'h04;
  localparam logic [4:0] C_BPR  = 5'h08;
  localparam logic [4:0] C_ACK  = 5'h0C;
  localparam logic [4:0] C_EOI  = 5'h10;

  function automatic logic [31:0] type_word(int num_irq);
    return 32'((num_irq / 32) - 1) & 32'h1F;
  endfunction

  // place a stored priority of 'bits' width at the top of a byte
  function automatic logic [7:0] prio_widen(logic [7:0] raw, int bits);
    return raw << (8 - bits);
  endfunction

  function automatic logic [31:0] ack_word(logic ok, logic [ID_W-1:0] id);
    return ok ? {22'd0, id} : {22'd0, SPURIOUS_ID};
  endfunction
endpackage

// File: rtl/pic_source_state.sv
module pic_source_state #(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_IRQ-1:0] edge_cfg,
  input  logic               ack_take,
  input  logic [IDX_W-1:0]   ack_id,
  input  logic               eoi_hit,
  input  logic [IDX_W-1:0]   eoi_id,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] active
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic prev_q, latch_q, act_q;
    logic rise, took, retired;

    assign rise    = irq_lines[g] & ~prev_q;
    assign took    = ack_take && (ack_id == IDX_W'(g));
    assign retired = eoi_hit && (eoi_id == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
        act_q   <= 1'b0;
      end else begin
        prev_q <= irq_lines[g];
        if (!edge_cfg[g])  latch_q <= 1'b0;
        else if (rise)     latch_q <= 1'b1;
        else if (took)     latch_q <= 1'b0;
        if (took)          act_q <= 1'b1;
        else if (retired)  act_q <= 1'b0;
      end
    end

    assign pending[g] = edge_cfg[g] ? latch_q : irq_lines[g];
    assign active[g]  = act_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5,
  parameter int IDX_W     = 6
) (
  input  logic [NUM_IRQ-1:0]                eligible,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
  output logic                              found,
  output logic [IDX_W-1:0]                  win_id,
  output logic [PRIO_BITS-1:0]              win_prio
);
  // ascending scan with strict compare: ties stay with the lower ID
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i] && (!found || prio[i] < win_prio)) begin
        found    = 1'b1;
        win_id   = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_cpu_port.sv
module pic_cpu_port
  import pic_pkg::*;
#(
  parameter int PRIO_BITS = 5,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 we,
  input  logic                 re,
  input  logic [4:0]           reg_off,
  input  logic [9:0]           wdata,
  input  logic                 dist_en,
  input  logic                 found,
  input  logic [IDX_W-1:0]     win_id,
  input  logic [PRIO_BITS-1:0] win_prio,
  input  logic                 any_active,
  output logic                 cpu_en,
  output logic                 irq_req,
  output logic                 ack_take,
  output logic                 eoi_req,
  output logic [ID_W-1:0]      eoi_id,
  output logic [31:0]          rd_data
);
  logic [7:0] pmr_q;
  logic [2:0] bpr_q;
  logic       deliver;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en <= 1'b0;
      pmr_q  <= 8'd0;
      bpr_q  <= 3'd0;
    end else if (sel && we) begin
      if (reg_off == C_CTRL) cpu_en <= wdata[0];
      if (reg_off == C_PMR)  pmr_q  <= wdata[7:0];
      if (reg_off == C_BPR)  bpr_q  <= wdata[2:0];
    end
  end

  assign deliver  = dist_en && cpu_en && found && !any_active &&
                    (prio_widen(8'(win_prio), PRIO_BITS) < pmr_q);
  assign irq_req  = deliver;
  assign ack_take = sel && re && (reg_off == C_ACK) && deliver;
  assign eoi_req  = sel && we && (reg_off == C_EOI);
  assign eoi_id   = wdata;

  always_comb begin
    rd_data = '0;
    if (sel) begin
      case (reg_off)
        C_CTRL:  rd_data = {31'd0, cpu_en};
        C_PMR:   rd_data = {24'd0, pmr_q};
        C_BPR:   rd_data = {29'd0, bpr_q};
        C_ACK:   rd_data = ack_word(deliver, ID_W'(win_id));
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [12:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_re,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               irq_req
);
  localparam int IDX_W      = $clog2(NUM_IRQ);
  localparam int EN_WORDS   = NUM_IRQ / 32;
  localparam int BYTE_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  logic        cpu_sel, dist_wr;
  logic [11:0] off;
  assign cpu_sel = bus_addr[12];
  assign off     = bus_addr[11:0];
  assign dist_wr = bus_we && !cpu_sel;

  logic                              dist_en;
  logic [NUM_IRQ-1:0]                enable_q;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic [NUM_IRQ-1:0][7:0]           target_q;
  logic [NUM_IRQ-1:0][1:0]           cfg_q;

  // event wires shared with the checker
  logic [NUM_IRQ-1:0] pending, active_vec, eligible, edge_vec;
  logic               any_active, found, ack_take, eoi_req, eoi_hit, cpu_en;
  logic [IDX_W-1:0]   win_id, eoi_idx;
  logic [PRIO_BITS-1:0] win_prio;
  logic [ID_W-1:0]    eoi_id;
  logic [31:0]        dist_rd, cpu_rd;

  // distribution registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en  <= 1'b0;
      enable_q <= '0;
      prio_q   <= '0;
      target_q <= '0;
      cfg_q    <= '0;
    end else if (dist_wr) begin
      if (off == D_CTRL) dist_en <= bus_wdata[0];
      for (int w = 0; w < EN_WORDS; w++) begin
        if (off == D_SETEN + 12'(4 * w))
          enable_q[32*w +: 32] <= enable_q[32*w +: 32] | bus_wdata;
        if (off == D_CLREN + 12'(4 * w))
          enable_q[32*w +: 32] <= enable_q[32*w +: 32] & ~bus_wdata;
      end
      for (int w = 0; w < BYTE_WORDS; w++) begin
        for (int k = 0; k < 4; k++) begin
          if (off == D_PRIO + 12'(4 * w))
            prio_q[4*w+k] <= bus_wdata[8*k+8-PRIO_BITS +: PRIO_BITS];
          if (off == D_TARGET + 12'(4 * w))
            target_q[4*w+k] <= bus_wdata[8*k +: 8];
        end
      end
      for (int w = 0; w < CFG_WORDS; w++) begin
        for (int k = 0; k < 16; k++) begin
          if (off == D_CFG + 12'(4 * w))
            cfg_q[16*w+k] <= bus_wdata[2*k +: 2];
        end
      end
    end
  end

  always_comb begin
    dist_rd = '0;
    if (off == D_CTRL) dist_rd = {31'd0, dist_en};
    if (off == D_TYPE) dist_rd = type_word(NUM_IRQ);
    for (int w = 0; w < EN_WORDS; w++) begin
      if (off == D_SETEN + 12'(4 * w) || off == D_CLREN + 12'(4 * w))
        dist_rd = enable_q[32*w +: 32];
    end
    for (int w = 0; w < BYTE_WORDS; w++) begin
      if (off == D_PRIO + 12'(4 * w))
        for (int k = 0; k < 4; k++)
          dist_rd[8*k +: 8] = prio_widen(8'(prio_q[4*w+k]), PRIO_BITS);
      if (off == D_TARGET + 12'(4 * w))
        for (int k = 0; k < 4; k++)
          dist_rd[8*k +: 8] = target_q[4*w+k];
    end
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (off == D_CFG + 12'(4 * w))
        for (int k = 0; k < 16; k++)
          dist_rd[2*k +: 2] = cfg_q[16*w+k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= cpu_sel ? cpu_rd : dist_rd;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_edge
    assign edge_vec[g] = cfg_q[g][1];
  end

  assign eligible   = enable_q & pending & ~active_vec;
  assign any_active = |active_vec;
  assign eoi_idx    = eoi_id[IDX_W-1:0];
  assign eoi_hit    = eoi_req && ({1'b0, eoi_id} < 11'(NUM_IRQ)) && active_vec[eoi_idx];

  pic_source_state #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_src (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .edge_cfg(edge_vec),
    .ack_take(ack_take), .ack_id(win_id), .eoi_hit(eoi_hit), .eoi_id(eoi_idx),
    .pending(pending), .active(active_vec)
  );

  pic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_arb (
    .eligible(eligible), .prio(prio_q), .found(found),
    .win_id(win_id), .win_prio(win_prio)
  );

  pic_cpu_port #(.PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .sel(cpu_sel && (off[11:5] == 7'd0)),
    .we(bus_we), .re(bus_re), .reg_off(off[4:0]), .wdata(bus_wdata[9:0]),
    .dist_en(dist_en), .found(found), .win_id(win_id), .win_prio(win_prio),
    .any_active(any_active), .cpu_en(cpu_en), .irq_req(irq_req),
    .ack_take(ack_take), .eoi_req(eoi_req), .eoi_id(eoi_id), .rd_data(cpu_rd)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_req,
  input logic               dist_en,
  input logic               cpu_en,
  input logic               any_active,
  input logic               ack_take,
  input logic               eoi_hit,
  input logic [NUM_IRQ-1:0] active_vec,
  input logic               bus_re,
  input logic [12:0]        bus_addr,
  input logic [31:0]        bus_rdata
);
  AST_REQ_NEEDS_BOTH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (dist_en && cpu_en)); // R5
  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> any_active); // R6
  AST_IDLE_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 13'h100C && !irq_req) |=> (bus_rdata == 32'd1023)); // R7
  AST_QUIET_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |-> !irq_req); // R9
  AST_SINGLE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active_vec)); // R9
  AST_RETIRE_ENDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !any_active); // R9
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .dist_en(dist_en),
  .cpu_en(cpu_en), .any_active(any_active), .ack_take(ack_take),
  .eoi_hit(eoi_hit), .active_vec(active_vec), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int NUM_IRQ = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [12:0]        bus_addr = '0;
  logic               bus_we = 1'b0;
  logic [31:0]        bus_wdata = '0;
  logic               bus_re = 1'b0;
  logic [31:0]        bus_rdata;
  logic [NUM_IRQ-1:0] irq_lines = '0;
  logic               irq_req;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] exp_v;
  string       tag_v;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_req(irq_req)
  );

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver: issue a read and push the expected word to the scoreboard
  task automatic rd(input logic [12:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #1;
    total++;
    if (irq_req !== e) begin
      fails++;
      $display("FAIL %s: irq_req=%b expected %b", t, irq_req, e);
    end
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    irq_lines[i] = v;
  endtask

  // monitor: compare registered read data one step after the sampling edge
  always @(posedge clk) begin
    if (bus_re) begin
      #1;
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        if (bus_rdata !== exp_v) begin
          fails++;
          $display("FAIL %s: read %h expected %h", tag_v, bus_rdata, exp_v);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk_irq(1'b0, "R5 reset request");
    rd(13'h004, 32'h1, "R1 type word");
    rd(13'h000, 32'h0, "R5 reset dist ctrl");
    rd(13'h100, 32'h0, "R2 reset enables");
    rd(13'h1004, 32'h0, "R10 reset mask");

    // mask and preemption registers
    wr(13'h1004, 32'h1F0);
    rd(13'h1004, 32'hF0, "R10 mask 8 bits");
    wr(13'h1008, 32'hFF);
    rd(13'h1008, 32'h7, "R10 preemption 3 bits");

    // priority truncation
    wr(13'h400, 32'hFF12_34FF);
    rd(13'h400, 32'hF810_30F8, "R3 priority low bits zero");
    wr(13'h400, 32'h0);

    // target and trigger readback
    wr(13'h800, 32'hA5C3_0102);
    rd(13'h800, 32'hA5C3_0102, "R4 target readback");
    wr(13'hC0C, 32'h5A5A_0000);
    rd(13'hC0C, 32'h5A5A_0000, "R4 trigger readback");
    wr(13'hC0C, 32'h0);

    // write-one set and clear banks
    wr(13'h104, 32'hF0);
    rd(13'h104, 32'hF0, "R2 set");
    wr(13'h104, 32'h3);
    rd(13'h104, 32'hF3, "R2 set accumulates");
    wr(13'h184, 32'h10);
    rd(13'h184, 32'hE3, "R2 clear bank readback");
    wr(13'h184, 32'h0);
    rd(13'h104, 32'hE3, "R2 zero write no effect");
    wr(13'h184, 32'hFFFF_FFFF);
    rd(13'h104, 32'h0, "R2 clear all");

    // gating by enables and mask, level line 5 at priority 0x40
    set_line(5, 1'b1);
    wr(13'h404, 32'h0000_4000);
    wr(13'h100, 32'h20);
    wr(13'h1004, 32'hFF);
    wr(13'h1000, 32'h1);
    chk_irq(1'b0, "R5 distribution disabled");
    wr(13'h000, 32'h1);
    chk_irq(1'b1, "R5 both enabled");
    wr(13'h1000, 32'h0);
    chk_irq(1'b0, "R5 processor disabled");
    wr(13'h1000, 32'h1);
    wr(13'h1004, 32'h40);
    chk_irq(1'b0, "R5 priority equal to mask");
    wr(13'h1004, 32'h48);
    chk_irq(1'b1, "R5 priority below mask");

    // acknowledge and retire of a level line
    rd(13'h100C, 32'd5, "R6 acknowledge id");
    chk_irq(1'b0, "R9 quiet in service");
    rd(13'h100C, 32'd1023, "R9 acknowledge while in service");
    wr(13'h1010, 32'd6);
    chk_irq(1'b0, "R9 mismatched retire ignored");
    rd(13'h100C, 32'd1023, "R9 still in service");
    wr(13'h1010, 32'd5);
    chk_irq(1'b1, "R8 level still high after retire");
    set_line(5, 1'b0);
    chk_irq(1'b0, "R8 level follows line");
    rd(13'h100C, 32'd1023, "R7 nothing pending");
    set_line(5, 1'b1);
    chk_irq(1'b1, "R7 spurious read left state");
    rd(13'h100C, 32'd5, "R7 line still claimable");
    wr(13'h1010, 32'd5);
    set_line(5, 1'b0);
    wr(13'h180, 32'h20);

    // priority order and tie on shared lines 33, 35, 40
    wr(13'h420, 32'h1000_2000);
    wr(13'h428, 32'h0000_0010);
    wr(13'h104, 32'h0000_010A);
    set_line(33, 1'b1);
    set_line(35, 1'b1);
    set_line(40, 1'b1);
    rd(13'h100C, 32'd35, "R6 tie goes to lower id");
    wr(13'h1010, 32'd35);
    set_line(35, 1'b0);
    rd(13'h100C, 32'd40, "R6 next most urgent");
    wr(13'h1010, 32'd40);
    set_line(40, 1'b0);
    rd(13'h100C, 32'd33, "R6 least urgent last");
    wr(13'h1010, 32'd33);
    set_line(33, 1'b0);
    chk_irq(1'b0, "R9 all retired");

    // edge line 7
    wr(13'hC00, 32'h0000_8000);
    wr(13'h100, 32'h80);
    set_line(7, 1'b1);
    set_line(7, 1'b0);
    chk_irq(1'b1, "R8 edge latched");
    rd(13'h100C, 32'd7, "R8 edge acknowledge");
    wr(13'h1010, 32'd7);
    chk_irq(1'b0, "R8 acknowledge cleared latch");
    wr(13'h180, 32'h80);
    set_line(7, 1'b1);
    set_line(7, 1'b0);
    chk_irq(1'b0, "R5 disabled line silent");
    wr(13'h100, 32'h80);
    chk_irq(1'b1, "R8 latched while disabled");
    rd(13'h100C, 32'd7, "R8 latched acknowledge");
    wr(13'h1010, 32'd7);
    chk_irq(1'b0, "R9 edge retired");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule